// File: doc/BRIEF.md
# Four-Channel DMA Programming Register File

This block is the byte-wide register interface that a processor uses to program a four-channel DMA controller. A 4-bit port offset with single-cycle write and read strobes selects the register. Each channel keeps a 16-bit start address and a 16-bit start count, each with a running copy, plus a mode byte and a mask bit. A shared command byte, a status byte and a byte-pointer toggle are held once for the whole block. The toggle lets software move 16-bit values through the 8-bit port as a low byte followed by a high byte.

The transfer engine sits on the other side. It reads every channel's programmed state from flat output vectors. It reports back through per-channel pulses that raise a request flag or a terminal-count flag, and it writes back updated running address and count values. Read data is registered and comes out one cycle after the read strobe, marked by a valid pulse.

Top module: `dmac_prog_regs`

## Requirements
- R1: After reset every channel is masked (mask vector 4'b1111), the byte toggle is 0, status and command are 0x00, every mode field is 0 (demand, increment, no reload, verify) and every address and count, start and running, is 0.
- R2: Offset 2n accesses the address of channel n and offset 2n+1 its count (n = 0..3). When the toggle is 0 the access touches bits 7..0, when it is 1 bits 15..8. Every read or write at offsets 0..7 flips the single toggle shared by all of those offsets.
- R3: A low-byte write puts the byte into bits 7..0 of both the start and the running register and zeroes bits 15..8. A high-byte write ORs the byte into bits 15..8 of both registers and leaves the other bits as they were.
- R4: A read at offset 8 returns {request flags of channels 3..0 in bits 7..4, terminal-count flags of channels 3..0 in bits 3..0}. Afterwards bits 3..0 are cleared and bits 7..4 are kept. A terminal-count flag that the engine sets in the same cycle as the read survives the read.
- R5: A write at offset 10 sets the mask of the channel given by data bits 1..0 to data bit 2. Other masks are unchanged.
- R6: A write at offset 11 programs the channel given by data bits 1..0. Bits 7..6 give the transfer kind (0 demand, 1 single, 2 block, 3 cascade), bit 5 selects a decrementing address, bit 4 enables reload at terminal count, and bits 3..2 give the direction (0 verify, 1 I/O to memory, 2 memory to I/O). Other channels' modes are unchanged.
- R7: Any write at offset 12 clears the byte toggle. Any write at offset 14 clears all four masks. A write at offset 15 loads masks 3..0 from data bits 3..0.
- R8: Any write at offset 13 sets all masks and clears the command, the status and the byte toggle. This takes priority over engine flag pulses in the same cycle. Addresses, counts and modes are kept.
- R9: A write at offset 9 with data bit 2 at 0 clears the request flag of the channel given by data bits 1..0. With bit 2 at 1 the write has no effect. An engine request pulse in the same cycle wins over the clear.
- R10: A write at offset 8 loads the command byte, which appears on the command output on the next cycle.
- R11: Reads at offsets 9..15 return 0xFF and leave the byte toggle unchanged.
- R12: An engine request or terminal-count pulse for channel n sets status bit n+4 or bit n. An engine write-back replaces the running address and count of channel n and leaves the start values alone. A processor write to the same register in the same cycle wins over the write-back.
- R13: Read data and the valid pulse appear on the cycle after the read strobe. If the read and write strobes are both high, only the write takes effect and no read data is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_ofs | input | 4 | Port offset |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| cpu_rvalid | output | 1 | High for one cycle when cpu_rdata holds a read result |
| eng_req_set | input | 4 | Per-channel pulse that raises the request flag |
| eng_tc_set | input | 4 | Per-channel pulse that raises the terminal-count flag |
| eng_wb_en | input | 4 | Per-channel write-back enable for running address and count |
| eng_wb_addr | input | 64 | Write-back running addresses, channel n at bits 16n+15..16n |
| eng_wb_cnt | input | 64 | Write-back running counts, channel n at bits 16n+15..16n |
| eng_mask | output | 4 | Per-channel mask bits |
| eng_cmd | output | 8 | Command byte |
| eng_base_addr | output | 64 | Start addresses, channel n at bits 16n+15..16n |
| eng_cur_addr | output | 64 | Running addresses |
| eng_base_cnt | output | 64 | Start counts |
| eng_cur_cnt | output | 64 | Running counts |
| eng_mode_kind | output | 8 | Transfer kind, channel n at bits 2n+1..2n |
| eng_addr_down | output | 4 | Decrementing address per channel |
| eng_autoinit | output | 4 | Reload at terminal count per channel |
| eng_dir | output | 8 | Transfer direction, channel n at bits 2n+1..2n |

## Verification
The embedded properties are checked on every cycle. They cover the toggle flipping on each address or count access, the reset-like result of a master clear, terminal-count flags being cleared by a status read and raised by engine pulses, the low-byte load and write-back rules of each channel, the 0xFF reply for unused offsets, and the absence of read data when both strobes are high. Some behaviours only the bench's scenarios can show, because each one is a chain of several accesses. These are whole 16-bit round trips through the shared toggle, the OR of a high byte into a running value that the engine has just changed, the survival of same-cycle flag pulses over a read or a clear, the masking and mode-programming encodings, and the fact that a master clear keeps the programmed addresses and modes.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int NUM_CH = 4;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int BYTE_W = 8;
  localparam int REG_W  = 2 * BYTE_W;

  // port offsets with fixed meaning (channel registers occupy 0..7)
  localparam logic [3:0] OFS_STATUS  = 4'd8;
  localparam logic [3:0] OFS_REQ     = 4'd9;
  localparam logic [3:0] OFS_MASK1   = 4'd10;
  localparam logic [3:0] OFS_MODE    = 4'd11;
  localparam logic [3:0] OFS_FFCLR   = 4'd12;
  localparam logic [3:0] OFS_MCLR    = 4'd13;
  localparam logic [3:0] OFS_MASKCLR = 4'd14;
  localparam logic [3:0] OFS_MASKALL = 4'd15;

  typedef enum logic [1:0] {XM_DEMAND, XM_SINGLE, XM_BLOCK, XM_CASCADE} xfer_kind_e;
  typedef enum logic [1:0] {XD_VERIFY, XD_IO2MEM, XD_MEM2IO, XD_RSVD} xfer_dir_e;

  typedef struct packed {
    xfer_kind_e kind;
    logic       down;
    logic       reload;
    xfer_dir_e  dir;
  } chan_mode_t;

  // merge one port byte into a 16-bit register according to the toggle
  function automatic logic [REG_W-1:0] pair_load(input logic [REG_W-1:0] prev,
                                                 input logic [BYTE_W-1:0] b,
                                                 input logic upper);
    if (upper) pair_load = prev | {b, {BYTE_W{1'b0}}};
    else       pair_load = {{BYTE_W{1'b0}}, b};
  endfunction

  function automatic logic [BYTE_W-1:0] pair_pick(input logic [REG_W-1:0] v,
                                                  input logic upper);
    pair_pick = upper ? v[REG_W-1:BYTE_W] : v[BYTE_W-1:0];
  endfunction

  function automatic chan_mode_t mode_decode(input logic [BYTE_W-1:0] b);
    chan_mode_t m;
    m.kind   = xfer_kind_e'(b[7:6]);
    m.down   = b[5];
    m.reload = b[4];
    m.dir    = xfer_dir_e'(b[3:2]);
    return m;
  endfunction

  function automatic logic [NUM_CH-1:0] ch_onehot(input logic [CH_W-1:0] c);
    logic [NUM_CH-1:0] v;
    v = '0;
    v[c] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/dmac_port_decode.sv
module dmac_port_decode
  import dmac_pkg::*;
(
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [3:0]        ofs_i,
  input  logic [2:0]        wsel_i,
  output logic              rd_eff_o,
  output logic              byte_acc_o,
  output logic [NUM_CH-1:0] addr_wr_o,
  output logic [NUM_CH-1:0] cnt_wr_o,
  output logic [NUM_CH-1:0] mode_wr_o,
  output logic [NUM_CH-1:0] req_clr_o,
  output logic              st_rd_o,
  output logic              cmd_wr_o,
  output logic              mask1_wr_o,
  output logic              ffclr_o,
  output logic              mclr_o,
  output logic              maskclr_o,
  output logic              maskall_o
);
  logic              chan_area;
  logic [NUM_CH-1:0] ofs_ch;

  // a write wins when both strobes are high
  assign rd_eff_o   = rd_i & ~wr_i;
  assign chan_area  = ~ofs_i[3];
  assign ofs_ch     = ch_onehot(ofs_i[CH_W:1]);
  assign byte_acc_o = (wr_i | rd_eff_o) & chan_area;

  assign addr_wr_o = (wr_i && chan_area && !ofs_i[0]) ? ofs_ch : '0;
  assign cnt_wr_o  = (wr_i && chan_area &&  ofs_i[0]) ? ofs_ch : '0;
  assign mode_wr_o = (wr_i && ofs_i == OFS_MODE) ? ch_onehot(wsel_i[CH_W-1:0]) : '0;
  assign req_clr_o = (wr_i && ofs_i == OFS_REQ && !wsel_i[2]) ?
                     ch_onehot(wsel_i[CH_W-1:0]) : '0;

  assign st_rd_o    = rd_eff_o && ofs_i == OFS_STATUS;
  assign cmd_wr_o   = wr_i && ofs_i == OFS_STATUS;
  assign mask1_wr_o = wr_i && ofs_i == OFS_MASK1;
  assign ffclr_o    = wr_i && ofs_i == OFS_FFCLR;
  assign mclr_o     = wr_i && ofs_i == OFS_MCLR;
  assign maskclr_o  = wr_i && ofs_i == OFS_MASKCLR;
  assign maskall_o  = wr_i && ofs_i == OFS_MASKALL;
endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
  import dmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_wr_i,
  input  logic              cnt_wr_i,
  input  logic              upper_i,
  input  logic [BYTE_W-1:0] wbyte_i,
  input  logic              mode_wr_i,
  input  chan_mode_t        mode_i,
  input  logic              wb_en_i,
  input  logic [REG_W-1:0]  wb_addr_i,
  input  logic [REG_W-1:0]  wb_cnt_i,
  output logic [REG_W-1:0]  base_addr_o,
  output logic [REG_W-1:0]  cur_addr_o,
  output logic [REG_W-1:0]  base_cnt_o,
  output logic [REG_W-1:0]  cur_cnt_o,
  output chan_mode_t        mode_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr_o <= '0;
      cur_addr_o  <= '0;
    end else if (addr_wr_i) begin
      base_addr_o <= pair_load(base_addr_o, wbyte_i, upper_i);
      cur_addr_o  <= pair_load(cur_addr_o, wbyte_i, upper_i);
    end else if (wb_en_i) begin
      cur_addr_o  <= wb_addr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_cnt_o <= '0;
      cur_cnt_o  <= '0;
    end else if (cnt_wr_i) begin
      base_cnt_o <= pair_load(base_cnt_o, wbyte_i, upper_i);
      cur_cnt_o  <= pair_load(cur_cnt_o, wbyte_i, upper_i);
    end else if (wb_en_i) begin
      cur_cnt_o  <= wb_cnt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_o <= '0;
    else if (mode_wr_i) mode_o <= mode_i;
  end

  // R3
  low_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr_i && !upper_i |=> cur_addr_o == {{BYTE_W{1'b0}}, $past(wbyte_i)} &&
                              base_addr_o == cur_addr_o);
  // R12
  writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_i && !addr_wr_i |=> cur_addr_o == $past(wb_addr_i) && $stable(base_addr_o));
endmodule

// File: rtl/dmac_ctrl_regs.sv
module dmac_ctrl_regs
  import dmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_acc_i,
  input  logic              st_rd_i,
  input  logic              cmd_wr_i,
  input  logic [NUM_CH-1:0] req_clr_i,
  input  logic              mask1_wr_i,
  input  logic              ffclr_i,
  input  logic              mclr_i,
  input  logic              maskclr_i,
  input  logic              maskall_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [NUM_CH-1:0] req_set_i,
  input  logic [NUM_CH-1:0] tc_set_i,
  output logic              ff_o,
  output logic [NUM_CH-1:0] mask_o,
  output logic [BYTE_W-1:0] status_o,
  output logic [BYTE_W-1:0] cmd_o
);
  logic [NUM_CH-1:0] req_q, tc_q, req_d, tc_d;

  assign status_o = {req_q, tc_q};

  always_comb begin
    req_d = (req_q & ~req_clr_i) | req_set_i;
    tc_d  = (st_rd_i ? '0 : tc_q) | tc_set_i;
    if (mclr_i) begin
      req_d = '0;
      tc_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      tc_q  <= '0;
    end else begin
      req_q <= req_d;
      tc_q  <= tc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ff_o <= 1'b0;
    else if (mclr_i || ffclr_i) ff_o <= 1'b0;
    else if (byte_acc_i)        ff_o <= ~ff_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mask_o <= '1;
    else if (mclr_i)     mask_o <= '1;
    else if (maskclr_i)  mask_o <= '0;
    else if (maskall_i)  mask_o <= wdata_i[NUM_CH-1:0];
    else if (mask1_wr_i) mask_o[wdata_i[CH_W-1:0]] <= wdata_i[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cmd_o <= '0;
    else if (mclr_i)   cmd_o <= '0;
    else if (cmd_wr_i) cmd_o <= wdata_i;
  end

  // R2
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_acc_i |=> ff_o != $past(ff_o));
  // R8
  master_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mclr_i |=> mask_o == '1 && status_o == '0 && !ff_o && cmd_o == '0);
  // R4
  tc_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_rd_i && tc_set_i == '0 && !mclr_i |=> tc_q == '0 && req_q == $past(req_d));
  // R12
  tc_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_set_i != '0 && !mclr_i |=> (tc_q & $past(tc_set_i)) == $past(tc_set_i));
endmodule

// File: rtl/dmac_prog_regs.sv
module dmac_prog_regs
  import dmac_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_wr,
  input  logic                    cpu_rd,
  input  logic [3:0]              cpu_ofs,
  input  logic [BYTE_W-1:0]       cpu_wdata,
  output logic [BYTE_W-1:0]       cpu_rdata,
  output logic                    cpu_rvalid,
  input  logic [NUM_CH-1:0]       eng_req_set,
  input  logic [NUM_CH-1:0]       eng_tc_set,
  input  logic [NUM_CH-1:0]       eng_wb_en,
  input  logic [NUM_CH*REG_W-1:0] eng_wb_addr,
  input  logic [NUM_CH*REG_W-1:0] eng_wb_cnt,
  output logic [NUM_CH-1:0]       eng_mask,
  output logic [BYTE_W-1:0]       eng_cmd,
  output logic [NUM_CH*REG_W-1:0] eng_base_addr,
  output logic [NUM_CH*REG_W-1:0] eng_cur_addr,
  output logic [NUM_CH*REG_W-1:0] eng_base_cnt,
  output logic [NUM_CH*REG_W-1:0] eng_cur_cnt,
  output logic [NUM_CH*2-1:0]     eng_mode_kind,
  output logic [NUM_CH-1:0]       eng_addr_down,
  output logic [NUM_CH-1:0]       eng_autoinit,
  output logic [NUM_CH*2-1:0]     eng_dir
);
  logic              rd_eff, byte_acc, st_rd, cmd_wr, mask1_wr;
  logic              ffclr, mclr, maskclr, maskall, ff;
  logic [NUM_CH-1:0] addr_wr, cnt_wr, mode_wr, req_clr;
  logic [BYTE_W-1:0] status, rd_val;
  chan_mode_t        mode_new;
  logic [REG_W-1:0]  cur_addr_a [NUM_CH];
  logic [REG_W-1:0]  cur_cnt_a  [NUM_CH];

  assign mode_new = mode_decode(cpu_wdata);

  dmac_port_decode u_dec (
    .wr_i(cpu_wr), .rd_i(cpu_rd), .ofs_i(cpu_ofs), .wsel_i(cpu_wdata[2:0]),
    .rd_eff_o(rd_eff), .byte_acc_o(byte_acc),
    .addr_wr_o(addr_wr), .cnt_wr_o(cnt_wr), .mode_wr_o(mode_wr), .req_clr_o(req_clr),
    .st_rd_o(st_rd), .cmd_wr_o(cmd_wr), .mask1_wr_o(mask1_wr), .ffclr_o(ffclr),
    .mclr_o(mclr), .maskclr_o(maskclr), .maskall_o(maskall)
  );

  dmac_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n), .byte_acc_i(byte_acc), .st_rd_i(st_rd),
    .cmd_wr_i(cmd_wr), .req_clr_i(req_clr), .mask1_wr_i(mask1_wr), .ffclr_i(ffclr),
    .mclr_i(mclr), .maskclr_i(maskclr), .maskall_i(maskall), .wdata_i(cpu_wdata),
    .req_set_i(eng_req_set), .tc_set_i(eng_tc_set),
    .ff_o(ff), .mask_o(eng_mask), .status_o(status), .cmd_o(eng_cmd)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    chan_mode_t m;
    dmac_chan_regs u_ch (
      .clk(clk), .rst_n(rst_n),
      .addr_wr_i(addr_wr[i]), .cnt_wr_i(cnt_wr[i]), .upper_i(ff), .wbyte_i(cpu_wdata),
      .mode_wr_i(mode_wr[i]), .mode_i(mode_new),
      .wb_en_i(eng_wb_en[i]),
      .wb_addr_i(eng_wb_addr[i*REG_W +: REG_W]),
      .wb_cnt_i(eng_wb_cnt[i*REG_W +: REG_W]),
      .base_addr_o(eng_base_addr[i*REG_W +: REG_W]),
      .cur_addr_o(cur_addr_a[i]),
      .base_cnt_o(eng_base_cnt[i*REG_W +: REG_W]),
      .cur_cnt_o(cur_cnt_a[i]),
      .mode_o(m)
    );
    assign eng_cur_addr[i*REG_W +: REG_W] = cur_addr_a[i];
    assign eng_cur_cnt[i*REG_W +: REG_W]  = cur_cnt_a[i];
    assign eng_mode_kind[i*2 +: 2]        = m.kind;
    assign eng_addr_down[i]               = m.down;
    assign eng_autoinit[i]                = m.reload;
    assign eng_dir[i*2 +: 2]              = m.dir;
  end

  always_comb begin
    if (!cpu_ofs[3])
      rd_val = pair_pick(cpu_ofs[0] ? cur_cnt_a[cpu_ofs[CH_W:1]] : cur_addr_a[cpu_ofs[CH_W:1]], ff);
    else if (cpu_ofs == OFS_STATUS)
      rd_val = status;
    else
      rd_val = 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rdata  <= '0;
      cpu_rvalid <= 1'b0;
    end else begin
      cpu_rvalid <= rd_eff;
      if (rd_eff) cpu_rdata <= rd_val;
    end
  end

  // R11
  unused_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && !cpu_wr && cpu_ofs > OFS_STATUS |=> cpu_rvalid && cpu_rdata == 8'hFF);
  // R13
  rd_wr_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && cpu_wr |=> !cpu_rvalid);
endmodule

// File: tb/dmac_prog_regs_test.sv
`timescale 1ns/1ps
module dmac_prog_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [3:0]  cpu_ofs = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_rvalid;
  logic [3:0]  eng_req_set = '0, eng_tc_set = '0, eng_wb_en = '0;
  logic [63:0] eng_wb_addr = '0, eng_wb_cnt = '0;
  logic [3:0]  eng_mask, eng_addr_down, eng_autoinit;
  logic [7:0]  eng_cmd, eng_mode_kind, eng_dir;
  logic [63:0] eng_base_addr, eng_cur_addr, eng_base_cnt, eng_cur_cnt;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  dmac_prog_regs uut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read bytes as the design returns them
  always @(negedge clk) begin
    if (rst_n && cpu_rvalid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R13 unexpected read data actual=%0h expected=none", cpu_rdata);
      end else begin
        string t;
        logic [7:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {56'd0, cpu_rdata}, {56'd0, e});
      end
    end
  end

  task automatic wr(input logic [3:0] o, input logic [7:0] d);
    cpu_wr = 1'b1; cpu_ofs = o; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] o, input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    cpu_rd = 1'b1; cpu_ofs = o;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic flags(input logic [3:0] rq, input logic [3:0] tc);
    eng_req_set = rq; eng_tc_set = tc;
    @(negedge clk);
    eng_req_set = '0; eng_tc_set = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mask", eng_mask, 4'hF);
    chk("R1 mode", {eng_mode_kind, eng_dir, eng_addr_down, eng_autoinit}, 0);
    chk("R1 addr", eng_cur_addr | eng_base_addr, 0);
    chk("R1 cnt", eng_cur_cnt | eng_base_cnt, 0);
    chk("R1 cmd", eng_cmd, 0);
    rd(4'd8, 8'h00, "R1 status");
    rd(4'd0, 8'h00, "R1 addr lo");
    rd(4'd0, 8'h00, "R1 addr hi");
    // R2 / R3 16-bit round trips
    wr(4'd2, 8'h34); wr(4'd2, 8'h12);
    chk("R3 ch1 base addr", eng_base_addr[31:16], 16'h1234);
    chk("R3 ch1 cur addr", eng_cur_addr[31:16], 16'h1234);
    rd(4'd2, 8'h34, "R2 ch1 addr lo");
    rd(4'd2, 8'h12, "R2 ch1 addr hi");
    wr(4'd3, 8'hCD); wr(4'd3, 8'hAB);
    chk("R2 ch1 count", eng_base_cnt[31:16], 16'hABCD);
    rd(4'd3, 8'hCD, "R2 ch1 cnt lo");
    rd(4'd3, 8'hAB, "R2 ch1 cnt hi");
    wr(4'd2, 8'h99);
    chk("R3 low clears upper", eng_cur_addr[31:16], 16'h0099);
    rd(4'd3, 8'hAB, "R2 shared toggle");
    wr(4'd2, 8'h34); wr(4'd2, 8'h12);
    // R3 OR into upper byte after a write-back (R12)
    wr(4'd4, 8'h22);
    eng_wb_en = 4'b0100; eng_wb_addr[47:32] = 16'hA000; eng_wb_cnt[47:32] = 16'h0777;
    @(negedge clk);
    eng_wb_en = '0;
    chk("R12 wb cur addr", eng_cur_addr[47:32], 16'hA000);
    chk("R12 wb cur cnt", eng_cur_cnt[47:32], 16'h0777);
    chk("R12 wb keeps base", eng_base_addr[47:32], 16'h0022);
    wr(4'd4, 8'h05);
    chk("R3 hi OR cur", eng_cur_addr[47:32], 16'hA500);
    chk("R3 hi OR base", eng_base_addr[47:32], 16'h0522);
    // R12 CPU write beats write-back on the same register
    eng_wb_en = 4'b0001; eng_wb_addr[15:0] = 16'h9999; eng_wb_cnt[15:0] = 16'h0123;
    wr(4'd0, 8'h77);
    eng_wb_en = '0;
    chk("R12 cpu wins addr", eng_cur_addr[15:0], 16'h0077);
    chk("R12 wb cnt same cycle", eng_cur_cnt[15:0], 16'h0123);
    wr(4'd12, 8'h00);
    rd(4'd0, 8'h77, "R7 toggle clear");
    rd(4'd0, 8'h00, "R2 ch0 hi");
    // R4 status
    flags(4'b0100, 4'b1010);
    rd(4'd8, 8'h4A, "R4 status full");
    rd(4'd8, 8'h40, "R4 tc cleared");
    exp_q.push_back(8'h40); tag_q.push_back("R4 read with tc pulse");
    cpu_rd = 1'b1; cpu_ofs = 4'd8; eng_tc_set = 4'b0001;
    @(negedge clk);
    cpu_rd = 1'b0; eng_tc_set = '0;
    rd(4'd8, 8'h41, "R4 tc survives read");
    rd(4'd8, 8'h40, "R4 cleared again");
    // R9 request clear
    flags(4'b0001, 4'b0000);
    wr(4'd9, 8'h06);
    rd(4'd8, 8'h50, "R9 bit2 set ignored");
    wr(4'd9, 8'h00);
    rd(4'd8, 8'h40, "R9 clear ch0");
    eng_req_set = 4'b0100;
    wr(4'd9, 8'h02);
    eng_req_set = '0;
    rd(4'd8, 8'h40, "R9 set wins");
    wr(4'd9, 8'h02);
    rd(4'd8, 8'h00, "R9 clear ch2");
    // R5 / R7 masks
    wr(4'd14, 8'h00); chk("R7 clear masks", eng_mask, 4'h0);
    wr(4'd10, 8'h05); chk("R5 set mask ch1", eng_mask, 4'b0010);
    wr(4'd10, 8'h01); chk("R5 clear mask ch1", eng_mask, 4'b0000);
    wr(4'd15, 8'hFA); chk("R7 load masks", eng_mask, 4'b1010);
    // R6 modes
    wr(4'd11, 8'h77);
    chk("R6 ch3 fields", {eng_mode_kind[7:6], eng_addr_down[3], eng_autoinit[3], eng_dir[7:6]},
        {2'd1, 1'b1, 1'b1, 2'd1});
    chk("R6 ch0 untouched", {eng_mode_kind[1:0], eng_autoinit[0]}, 0);
    wr(4'd11, 8'h88);
    chk("R6 ch0 block mem2io", {eng_mode_kind[1:0], eng_dir[1:0]}, {2'd2, 2'd2});
    chk("R6 ch3 kept", eng_mode_kind[7:6], 2'd1);
    // R10 command
    wr(4'd8, 8'h04); chk("R10 cmd", eng_cmd, 8'h04);
    // R11 unimplemented reads keep the toggle
    rd(4'd0, 8'h77, "R11 pre lo");
    rd(4'd13, 8'hFF, "R11 ofs13");
    rd(4'd9, 8'hFF, "R11 ofs9");
    rd(4'd15, 8'hFF, "R11 ofs15");
    rd(4'd0, 8'h00, "R11 toggle kept");
    // R13 both strobes: write only
    cpu_rd = 1'b1; cpu_wr = 1'b1; cpu_ofs = 4'd0; cpu_wdata = 8'h66;
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    chk("R13 no read data", cpu_rvalid, 0);
    chk("R13 write done", eng_cur_addr[15:0], 16'h0066);
    rd(4'd0, 8'h00, "R13 toggle moved once");
    rd(4'd0, 8'h66, "R13 low byte");
    // R8 master clear
    flags(4'b1000, 4'b0010);
    wr(4'd0, 8'h11);
    eng_tc_set = 4'b0100;
    wr(4'd13, 8'h00);
    eng_tc_set = '0;
    chk("R8 masks", eng_mask, 4'hF);
    chk("R8 cmd", eng_cmd, 0);
    chk("R8 addr kept", eng_base_addr[31:16], 16'h1234);
    chk("R8 mode kept", eng_mode_kind[7:6], 2'd1);
    rd(4'd8, 8'h00, "R8 status cleared");
    rd(4'd2, 8'h34, "R8 toggle cleared");
    repeat (2) @(negedge clk);
    chk("R13 all reads returned", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule